// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces the column address for each data beat of a memory read or write burst. When a column command begins, it takes the starting column together with the burst length and burst order from the mode settings held in the controller. It then presents one column per beat. The downstream datapath steps it forward with an advance enable until the burst ends.

Two orders are supported. In the sequential order, the low column bits count upward and wrap inside the block that the burst length aligns to. In the interleaved order, each beat's low bits are the starting low bits XORed with the beat number. Only the low bits covered by the burst length change; all column bits above them stay at the starting value. Flags mark the first and the final beat.

A new command arriving mid-burst restarts the sequence from the new column. Column commands must be spaced at least two clocks apart, so a command on the clock directly after an accepted one is dropped. An unsupported length code is reported on an error flag and produces no beats.

Top module: `burst_colseq`

## Requirements
- R1: After reset, `col_valid`, `first_beat`, `last_beat` and `len_error` are all low.
- R2: The length code `mode_len` is sampled on an accepted start. Code 3'b010 gives 4 beats and code 3'b011 gives 8 beats. The order bit `mode_ilv` is sampled at the same time: 0 selects sequential and 1 selects interleaved.
- R3: Column bits at positions 2 and up are held at the start value for a 4-beat burst. Bits at positions 3 and up are held for an 8-beat burst.
- R4: In sequential order, beat i carries low bits (s + i) mod BL, where s is the start column's low bits (2 bits for BL=4, 3 bits for BL=8). For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R5: In interleaved order, beat i carries low bits s XOR i. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R6: `col_valid` rises on the clock after an accepted start with a legal code. Each clock with `advance` high moves to the next beat. Without `advance`, the beat and `col_out` hold.
- R7: `first_beat` is high on beat 0 and `last_beat` is high on beat BL-1. An advance on the last beat ends the burst, and `col_valid` is low on the next clock.
- R8: An accepted start during an active burst restarts the sequence at beat 0 from the new column, length and order.
- R9: An accepted start with any code other than 3'b010 or 3'b011 sets `len_error` and leaves `col_valid` low. The next accepted start with a legal code clears `len_error`.
- R10: A start is accepted only if no start was accepted on the previous clock. A start on the clock directly after an accepted one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Column command strobe |
| start_col | input | COL_W | Starting column of the command |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| advance | input | 1 | Step to the next beat |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| first_beat | output | 1 | Current beat is beat 0 |
| last_beat | output | 1 | Current beat is beat BL-1 |
| len_error | output | 1 | Last accepted start carried a reserved length code |

## Verification
Every cycle, the assertions check the following:
- the two-clock spacing of accepted starts;
- that an error excludes beats;
- that a burst ends after an advance on its last beat;
- that the beat holds without an advance;
- that the upper column bits stay put across a step;
- that a legal start lands on a first beat.

The actual column order can only be shown by the bench's scenarios. This includes the sequential wrap and the XOR pattern for both lengths, restarts in mid-burst, and the ignored back-to-back start. The bench compares these against literal sequences and against its own queue-based model on every clock.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

  localparam int BEAT_IDX_W = 3;
  localparam logic [2:0] LEN_CODE_FOUR  = 3'b010;
  localparam logic [2:0] LEN_CODE_EIGHT = 3'b011;

  // a length code that the generator can serve
  function automatic logic code_is_legal(input logic [2:0] code);
    return (code == LEN_CODE_FOUR) || (code == LEN_CODE_EIGHT);
  endfunction

  function automatic logic code_is_eight(input logic [2:0] code);
    return code == LEN_CODE_EIGHT;
  endfunction

  // index of the final beat for a given length
  function automatic logic [BEAT_IDX_W-1:0] final_index(input logic eight);
    return eight ? 3'd7 : 3'd3;
  endfunction

  // low column bits carried by beat idx
  function automatic logic [BEAT_IDX_W-1:0] low_bits_for_beat(
    input logic [BEAT_IDX_W-1:0] start_low,
    input logic [BEAT_IDX_W-1:0] idx,
    input logic                  eight,
    input logic                  ilv
  );
    logic [BEAT_IDX_W-1:0] mask;
    logic [BEAT_IDX_W-1:0] raw;
    mask = eight ? 3'b111 : 3'b011;
    raw  = ilv ? (start_low ^ idx) : (start_low + idx);
    return raw & mask;
  endfunction

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_colseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] mode_len,
  output logic       take_start,
  output logic       load_ok,
  output logic       load_bad,
  output logic       len8
);

  logic took_prev;

  // spacing rule: no two accepted starts on adjacent clocks
  assign take_start = start & ~took_prev;
  assign load_ok    = take_start & code_is_legal(mode_len);
  assign load_bad   = take_start & ~code_is_legal(mode_len);
  assign len8       = code_is_eight(mode_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) took_prev <= 1'b0;
    else        took_prev <= take_start;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_colseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_ok,
  input  logic                  load_bad,
  input  logic                  load_len8,
  input  logic                  advance,
  output logic                  active,
  output logic [BEAT_IDX_W-1:0] idx,
  output logic                  len8_q,
  output logic                  at_first,
  output logic                  at_last
);

  logic step;

  assign at_first = active && (idx == '0);
  assign at_last  = active && (idx == final_index(len8_q));
  assign step     = active && advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      len8_q <= 1'b0;
    end else if (load_ok) begin
      active <= 1'b1;
      idx    <= '0;
      len8_q <= load_len8;
    end else if (load_bad) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (step) begin
      if (at_last) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_ok,
  input  logic [COL_W-1:0]      load_col,
  input  logic                  load_ilv,
  input  logic [BEAT_IDX_W-1:0] idx,
  input  logic                  len8_q,
  output logic [COL_W-1:0]      col
);

  logic [COL_W-1:0]      base_q;
  logic                  ilv_q;
  logic [BEAT_IDX_W-1:0] low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else if (load_ok) begin
      base_q <= load_col;
      ilv_q  <= load_ilv;
    end
  end

  assign low = low_bits_for_beat(base_q[BEAT_IDX_W-1:0], idx, len8_q, ilv_q);

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < BEAT_IDX_W - 1) begin : g_always_moves
      assign col[b] = low[b];
    end else if (b == BEAT_IDX_W - 1) begin : g_moves_if_eight
      assign col[b] = len8_q ? low[b] : base_q[b];
    end else begin : g_held
      assign col[b] = base_q[b];
    end
  end

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             advance,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             first_beat,
  output logic             last_beat,
  output logic             len_error
);

  // named internal events, watched by the checker
  logic                  take_start;
  logic                  load_ok;
  logic                  load_bad;
  logic                  len8_in;
  logic                  active;
  logic [BEAT_IDX_W-1:0] idx;
  logic                  len8_q;
  logic                  err_q;

  burst_mode_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_len   (mode_len),
    .take_start (take_start),
    .load_ok    (load_ok),
    .load_bad   (load_bad),
    .len8       (len8_in)
  );

  burst_beat_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ok   (load_ok),
    .load_bad  (load_bad),
    .load_len8 (len8_in),
    .advance   (advance),
    .active    (active),
    .idx       (idx),
    .len8_q    (len8_q),
    .at_first  (first_beat),
    .at_last   (last_beat)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ok  (load_ok),
    .load_col (start_col),
    .load_ilv (mode_ilv),
    .idx      (idx),
    .len8_q   (len8_q),
    .col      (col_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (load_bad) err_q <= 1'b1;
    else if (load_ok)  err_q <= 1'b0;
  end

  assign col_valid = active;
  assign len_error = err_q;

endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic             take_start,
  input logic             load_ok,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             first_beat,
  input logic             last_beat,
  input logic             len_error
);

  // R10: accepted starts never on adjacent clocks
  a_r10_start_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> !take_start);

  // R9: error excludes beats
  a_r9_error_no_beats: assert property (@(posedge clk) disable iff (!rst_n)
    len_error |-> !col_valid);

  // R7: advance on the last beat ends the burst
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && last_beat && advance && !take_start) |=> !col_valid);

  // R7: first and last never coincide
  a_r7_flags_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !(first_beat && last_beat));

  // R6: no advance, nothing moves
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !advance && !take_start) |=> (col_valid && $stable(col_out)));

  // R3: upper column bits do not change across a step
  a_r3_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && advance && !last_beat && !take_start)
      |=> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  // R8: a legal start lands on beat 0
  a_r8_restart_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (col_valid && first_beat && !len_error));

endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .take_start (take_start),
  .load_ok    (load_ok),
  .col_out    (col_out),
  .col_valid  (col_valid),
  .first_beat (first_beat),
  .last_beat  (last_beat),
  .len_error  (len_error)
);

// File: tb/burst_colseq_test.sv
module burst_colseq_test;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       mode_len = 3'b010;
  logic             mode_ilv = 1'b0;
  logic             advance = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, first_beat, last_beat, len_error;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_colseq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .mode_len(mode_len), .mode_ilv(mode_ilv), .advance(advance),
    .col_out(col_out), .col_valid(col_valid), .first_beat(first_beat),
    .last_beat(last_beat), .len_error(len_error)
  );

  // behavioural model: queue of remaining columns
  int q[$];
  int m_bl = 0;
  bit m_err = 0;
  bit m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_err = 0; m_prev = 0; m_bl = 0;
    end else begin
      bit take;
      take = start && !m_prev;
      if (take) begin
        if (mode_len == 3'd2 || mode_len == 3'd3) begin
          int s, lo;
          m_bl = (mode_len == 3'd3) ? 8 : 4;
          s = int'(start_col);
          lo = s % m_bl;
          q.delete();
          for (int i = 0; i < m_bl; i++) begin
            int nl;
            nl = mode_ilv ? (lo ^ i) : ((lo + i) % m_bl);
            q.push_back(s - lo + nl);
          end
          m_err = 0;
        end else begin
          q.delete();
          m_err = 1;
        end
      end else if (advance && q.size() > 0) begin
        void'(q.pop_front());
      end
      m_prev = take;
    end
  end

  // compare a few ns after each edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      bit ev;
      total++;
      ev = q.size() > 0;
      if (col_valid !== ev) begin
        bad++; $display("FAIL R6 model col_valid act=%0b exp=%0b", col_valid, ev);
      end else if (ev && int'(col_out) != q[0]) begin
        bad++; $display("FAIL R4 R5 R3 model col act=%0d exp=%0d", col_out, q[0]);
      end else if (ev && (first_beat !== (q.size() == m_bl) || last_beat !== (q.size() == 1))) begin
        bad++; $display("FAIL R7 model flags act=%0b%0b exp=%0b%0b",
                        first_beat, last_beat, q.size() == m_bl, q.size() == 1);
      end else if (len_error !== m_err) begin
        bad++; $display("FAIL R9 model len_error act=%0b exp=%0b", len_error, m_err);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input bit ilv, input int col);
    @(negedge clk);
    start = 1'b1; mode_len = code; mode_ilv = ilv; start_col = COL_W'(col);
    @(negedge clk);
    start = 1'b0;
  endtask

  // start a burst and walk it with advance held high, against a literal list
  task automatic walk(input logic [2:0] code, input bit ilv, input int col,
                      input int exp[8], input int n, input string tag);
    issue(code, ilv, col);
    advance = 1'b1;
    for (int i = 0; i < n; i++) begin
      check(col_valid && int'(col_out) == exp[i], tag, int'(col_out), exp[i]);
      if (i == 0)   check(first_beat === 1'b1, "R7 first flag", first_beat, 1);
      if (i == n-1) check(last_beat === 1'b1, "R7 last flag", last_beat, 1);
      @(negedge clk);
    end
    advance = 1'b0;
    check(col_valid === 1'b0, "R7 burst ended", col_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e[8];
    repeat (3) @(negedge clk);
    check(!col_valid && !first_beat && !last_beat && !len_error, "R1 reset outputs",
          {col_valid, first_beat, last_beat, len_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!col_valid && !len_error, "R1 after release", {col_valid, len_error}, 0);

    e = '{5, 6, 7, 0, 1, 2, 3, 4};
    walk(3'b011, 0, 5, e, 8, "R4 R2 seq len8 start5");
    e = '{5, 4, 7, 6, 1, 0, 3, 2};
    walk(3'b011, 1, 5, e, 8, "R5 R2 ilv len8 start5");
    e = '{46, 47, 44, 45, 0, 0, 0, 0};
    walk(3'b010, 0, 46, e, 4, "R3 R4 seq len4 upper held");
    e = '{497, 496, 499, 498, 0, 0, 0, 0};
    walk(3'b010, 1, 497, e, 4, "R3 R5 ilv len4 upper held");
    e = '{685, 686, 687, 680, 681, 682, 683, 684};
    walk(3'b011, 0, 685, e, 8, "R3 R4 seq len8 bit2 moves");

    // R6 hold without advance
    issue(3'b011, 1, 3);
    repeat (3) begin
      check(col_valid && col_out == 3, "R6 hold no advance", int'(col_out), 3);
      @(negedge clk);
    end
    advance = 1'b1; @(negedge clk); advance = 1'b0;
    check(col_out == 2, "R6 one step", int'(col_out), 2);
    @(negedge clk);
    check(col_out == 2 && !first_beat, "R6 hold after step", int'(col_out), 2);

    // R8 restart mid-burst
    issue(3'b011, 0, 5);
    advance = 1'b1; repeat (3) @(negedge clk); advance = 1'b0;
    e = '{2, 3, 0, 1, 0, 0, 0, 0};
    walk(3'b010, 0, 2, e, 4, "R8 restart seq len4");

    // R9 reserved code
    issue(3'b111, 0, 9);
    check(len_error && !col_valid, "R9 reserved code", {len_error, col_valid}, 2);
    issue(3'b000, 1, 9);
    check(len_error && !col_valid, "R9 reserved code 000", {len_error, col_valid}, 2);
    issue(3'b010, 0, 9);
    check(!len_error && col_valid && col_out == 9, "R9 cleared by legal start",
          int'(col_out), 9);
    advance = 1'b1; repeat (4) @(negedge clk); advance = 1'b0;

    // R10 back-to-back start ignored
    @(negedge clk);
    start = 1'b1; mode_len = 3'b011; mode_ilv = 0; start_col = 10'd1;
    @(negedge clk);
    start_col = 10'd6; mode_len = 3'b010;
    @(negedge clk);
    start = 1'b0;
    check(col_valid && col_out == 1, "R10 second start ignored", int'(col_out), 1);
    advance = 1'b1; @(negedge clk); advance = 1'b0;
    check(col_out == 2, "R10 burst kept going", int'(col_out), 2);
    advance = 1'b1; repeat (8) @(negedge clk); advance = 1'b0;

    // pattern sweep checked by the model each clock
    begin
      int seed = 7;
      for (int k = 0; k < 400; k++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        @(negedge clk);
        start     = (seed[4:2] == 3'd0);
        mode_len  = seed[9] ? (seed[10] ? 3'b011 : 3'b010) : seed[13:11];
        mode_ilv  = seed[14];
        start_col = COL_W'(seed[25:16]);
        advance   = seed[27] | seed[28];
      end
      @(negedge clk);
      start = 1'b0; advance = 1'b0;
    end
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule